// File: doc/BRIEF.md
# Dual-Core Hardware Lock Bank

This block holds a set of one-bit mutual-exclusion flags that two processor cores share. Each core reaches the bank through its own simple register port: a select, a byte address, a read strobe, a write strobe and a registered read-data bus. A core takes a flag by reading the flag's word. The read itself is the claim, so no separate test-and-set sequence is needed. A core gives the flag back by writing anything to the same word.

A claim read returns a one-hot word when the flag was free: bit n is set for flag n. It returns zero when the flag was already taken. When both cores reach for the same free flag in one cycle, core 0 always wins. A word at offset zero returns a bitmap of every flag, which is useful for debugging. Read data is registered and appears in the cycle after the strobe. The lock state updates on the same clock edge, so the next access from either core sees the result of the claim.

Top module: `hw_lock_bank`

## Requirements
- R1: After synchronous reset every flag is free, a status read returns 0, and both read-data buses are 0.
- R2: The byte address map is as follows. The status word is at offset 0x00. Flag n sits at offset 4*NUM_LOCKS + 4*n, which for the default of 32 flags spans 0x80 to 0xFC. Read data for a strobe in one cycle appears on that port's read-data bus in the next cycle.
- R3: A read of a free flag n claims it and returns a word with only bit n set.
- R4: A read of a flag that is already held returns 0 and leaves the flag held.
- R5: A write of any data value to flag n's address frees flag n. A write to the status word, or to an unmapped offset, changes no flag.
- R6: If both cores read the same free flag in the same cycle, core 0 receives the one-hot code and core 1 receives 0. The flag ends up held.
- R7: If one core frees a flag in the same cycle that the other core reads it, the read returns 0. After that edge the flag is free.
- R8: A status read returns the flag bitmap with bit n set to 1 when flag n is held. Either core may read it.
- R9: A claim made in one cycle is seen as held by a read from either core in the following cycle.
- R10: The read-data bus is 0 in any cycle after a cycle with no read, with the select low, or with an unmapped read address. If one port raises both strobes in the same cycle, only the read is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| c0_sel | input | 1 | Core 0 port select |
| c0_addr | input | ADDR_W | Core 0 byte address |
| c0_rd | input | 1 | Core 0 read strobe (claim or status) |
| c0_wr | input | 1 | Core 0 write strobe (release) |
| c0_rdata | output | DATA_W | Core 0 registered read data |
| c1_sel | input | 1 | Core 1 port select |
| c1_addr | input | ADDR_W | Core 1 byte address |
| c1_rd | input | 1 | Core 1 read strobe (claim or status) |
| c1_wr | input | 1 | Core 1 write strobe (release) |
| c1_rdata | output | DATA_W | Core 1 registered read data |

## Verification
The bench targets same-cycle contention on one flag. A design that swapped the priority, or granted both cores, would hand core 1 a nonzero code or give both cores the flag. It also drives a release by one core against a claim by the other in the same cycle. Letting the release win inside that cycle would return a success code, and a design that let the claim stick would leave the flag locked afterwards. The edges of the map are covered as well: flag 0 and the top flag, status writes, reads with the select low, and reads with both strobes raised. A design that got these wrong would misplace the one-hot bit, lose a held flag, or claim without being selected.

// File: rtl/hwl_pkg.sv
package hwl_pkg;
  // Byte offset of the first flag word for a bank of n flags.
  function automatic int unsigned flag_region_base(input int unsigned n);
    return 4 * n;
  endfunction

  // Byte offset of flag idx inside a bank of n flags.
  function automatic int unsigned flag_offset(input int unsigned n, input int unsigned idx);
    return flag_region_base(n) + 4 * idx;
  endfunction

  localparam int unsigned NUM_PORTS = 2;
endpackage

// File: rtl/hwl_port_dec.sv
module hwl_port_dec #(
  parameter int unsigned NUM_LOCKS = 32,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                 sel,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 rd,
  input  logic                 wr,
  output logic [NUM_LOCKS-1:0] claim,
  output logic [NUM_LOCKS-1:0] release_v,
  output logic                 stat_rd
);
  import hwl_pkg::*;

  logic rd_act;
  logic wr_act;

  // A read strobe suppresses a write raised in the same cycle.
  assign rd_act  = sel & rd;
  assign wr_act  = sel & wr & ~rd;
  assign stat_rd = rd_act && (addr == '0);

  for (genvar gi = 0; gi < NUM_LOCKS; gi++) begin : g_flag
    localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(flag_offset(NUM_LOCKS, gi));
    assign claim[gi]     = rd_act && (addr == FLAG_ADDR);
    assign release_v[gi] = wr_act && (addr == FLAG_ADDR);
  end
endmodule

// File: rtl/hwl_arbiter.sv
module hwl_arbiter #(
  parameter int unsigned NUM_LOCKS = 32
) (
  input  logic [NUM_LOCKS-1:0] state_q,
  input  logic [NUM_LOCKS-1:0] req0,
  input  logic [NUM_LOCKS-1:0] req1,
  input  logic [NUM_LOCKS-1:0] rel0,
  input  logic [NUM_LOCKS-1:0] rel1,
  output logic [NUM_LOCKS-1:0] grant0,
  output logic [NUM_LOCKS-1:0] grant1,
  output logic [NUM_LOCKS-1:0] state_d
);
  logic [NUM_LOCKS-1:0] free_v;

  // Grants are judged on the state before this edge, so a same-cycle
  // release cannot make a flag look free to the other core.
  always_comb begin
    free_v  = ~state_q;
    grant0  = req0 & free_v;
    grant1  = req1 & free_v & ~req0;
    state_d = (state_q & ~(rel0 | rel1)) | grant0 | grant1;
  end
endmodule

// File: rtl/hwl_rdata_reg.sv
module hwl_rdata_reg #(
  parameter int unsigned NUM_LOCKS = 32,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 stat_rd,
  input  logic [NUM_LOCKS-1:0] grant,
  input  logic [NUM_LOCKS-1:0] state_q,
  output logic [DATA_W-1:0]    rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (stat_rd) begin
      rdata <= DATA_W'(state_q);
    end else begin
      rdata <= DATA_W'(grant);
    end
  end
endmodule

// File: rtl/hw_lock_bank.sv
module hw_lock_bank #(
  parameter int unsigned NUM_LOCKS = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = $clog2(NUM_LOCKS * 8)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              c0_sel,
  input  logic [ADDR_W-1:0] c0_addr,
  input  logic              c0_rd,
  input  logic              c0_wr,
  output logic [DATA_W-1:0] c0_rdata,
  input  logic              c1_sel,
  input  logic [ADDR_W-1:0] c1_addr,
  input  logic              c1_rd,
  input  logic              c1_wr,
  output logic [DATA_W-1:0] c1_rdata
);
  import hwl_pkg::*;

  localparam int unsigned NP = NUM_PORTS;

  logic [NP-1:0]                p_sel;
  logic [NP-1:0][ADDR_W-1:0]    p_addr;
  logic [NP-1:0]                p_rd;
  logic [NP-1:0]                p_wr;
  logic [NP-1:0][NUM_LOCKS-1:0] p_claim;
  logic [NP-1:0][NUM_LOCKS-1:0] p_rel;
  logic [NP-1:0]                p_stat;
  logic [NP-1:0][NUM_LOCKS-1:0] p_grant;
  logic [NP-1:0][DATA_W-1:0]    p_rdata;

  logic [NUM_LOCKS-1:0] lock_q;
  logic [NUM_LOCKS-1:0] lock_d;

  assign p_sel  = {c1_sel, c0_sel};
  assign p_addr = {c1_addr, c0_addr};
  assign p_rd   = {c1_rd, c0_rd};
  assign p_wr   = {c1_wr, c0_wr};

  for (genvar gp = 0; gp < NP; gp++) begin : g_port
    hwl_port_dec #(.NUM_LOCKS(NUM_LOCKS), .ADDR_W(ADDR_W)) u_dec (
      .sel       (p_sel[gp]),
      .addr      (p_addr[gp]),
      .rd        (p_rd[gp]),
      .wr        (p_wr[gp]),
      .claim     (p_claim[gp]),
      .release_v (p_rel[gp]),
      .stat_rd   (p_stat[gp])
    );

    hwl_rdata_reg #(.NUM_LOCKS(NUM_LOCKS), .DATA_W(DATA_W)) u_rdata (
      .clk     (clk),
      .rst     (rst),
      .stat_rd (p_stat[gp]),
      .grant   (p_grant[gp]),
      .state_q (lock_q),
      .rdata   (p_rdata[gp])
    );
  end

  hwl_arbiter #(.NUM_LOCKS(NUM_LOCKS)) u_arb (
    .state_q (lock_q),
    .req0    (p_claim[0]),
    .req1    (p_claim[1]),
    .rel0    (p_rel[0]),
    .rel1    (p_rel[1]),
    .grant0  (p_grant[0]),
    .grant1  (p_grant[1]),
    .state_d (lock_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= '0;
    end else begin
      lock_q <= lock_d;
    end
  end

  assign c0_rdata = p_rdata[0];
  assign c1_rdata = p_rdata[1];
endmodule

// File: rtl/hw_lock_bank_chk.sv
module hw_lock_bank_chk #(
  parameter int unsigned NUM_LOCKS = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 c0_sel,
  input logic [ADDR_W-1:0]    c0_addr,
  input logic                 c0_rd,
  input logic [DATA_W-1:0]    c0_rdata,
  input logic                 c1_sel,
  input logic [ADDR_W-1:0]    c1_addr,
  input logic                 c1_rd,
  input logic [DATA_W-1:0]    c1_rdata,
  input logic [NUM_LOCKS-1:0] state
);
  localparam int unsigned IW = $clog2(NUM_LOCKS);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(4 * NUM_LOCKS);

  logic [ADDR_W-1:0] off0, off1;
  logic [IW-1:0]     idx0, idx1;
  logic              clm0, clm1, held0;

  assign off0  = c0_addr - BASE;
  assign off1  = c1_addr - BASE;
  assign idx0  = off0[IW+1:2];
  assign idx1  = off1[IW+1:2];
  assign clm0  = c0_sel && c0_rd && (c0_addr >= BASE) && (c0_addr[1:0] == 2'b00);
  assign clm1  = c1_sel && c1_rd && (c1_addr >= BASE) && (c1_addr[1:0] == 2'b00);
  assign held0 = state[idx0];

  AST_RESET_FREE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (state == '0)); // R1

  AST_HELD_GIVES_ZERO: assert property (@(posedge clk) disable iff (rst)
    (clm0 && held0) |=> (c0_rdata == '0)); // R4

  AST_FREE_GIVES_CODE: assert property (@(posedge clk) disable iff (rst)
    (clm0 && !held0) |=> (c0_rdata != '0) && $onehot0(c0_rdata)); // R3

  AST_CORE0_WINS: assert property (@(posedge clk) disable iff (rst)
    (clm0 && clm1 && (idx0 == idx1)) |=> (c1_rdata == '0)); // R6

  AST_CLAIM_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (clm0 && !held0) |=> (state[$past(idx0)] == 1'b1)); // R9

  AST_IDLE_ZERO0: assert property (@(posedge clk) disable iff (rst)
    !(c0_sel && c0_rd) |=> (c0_rdata == '0)); // R10

  AST_IDLE_ZERO1: assert property (@(posedge clk) disable iff (rst)
    !(c1_sel && c1_rd) |=> (c1_rdata == '0)); // R10
endmodule

bind hw_lock_bank hw_lock_bank_chk #(
  .NUM_LOCKS(NUM_LOCKS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst),
  .c0_sel(c0_sel), .c0_addr(c0_addr), .c0_rd(c0_rd), .c0_rdata(c0_rdata),
  .c1_sel(c1_sel), .c1_addr(c1_addr), .c1_rd(c1_rd), .c1_rdata(c1_rdata),
  .state(lock_q)
);

// File: tb/tb_hw_lock_bank.sv
module tb_hw_lock_bank;
  localparam int N  = 32;
  localparam int AW = 8;

  typedef enum int {IDLE, CLAIM, REL, STAT, WSTAT, NOSEL, RDWR} op_e;

  typedef struct {
    logic [31:0] e0;
    logic [31:0] e1;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic c0_sel = 0, c0_rd = 0, c0_wr = 0;
  logic c1_sel = 0, c1_rd = 0, c1_wr = 0;
  logic [AW-1:0] c0_addr = '0, c1_addr = '0;
  logic [31:0] c0_rdata, c1_rdata;

  int total = 0;
  int bad   = 0;
  logic [31:0] model = '0;
  exp_t q[$];
  bit done = 0;

  always #2 clk = ~clk;

  hw_lock_bank dut (
    .clk(clk), .rst(rst),
    .c0_sel(c0_sel), .c0_addr(c0_addr), .c0_rd(c0_rd), .c0_wr(c0_wr), .c0_rdata(c0_rdata),
    .c1_sel(c1_sel), .c1_addr(c1_addr), .c1_rd(c1_rd), .c1_wr(c1_wr), .c1_rdata(c1_rdata)
  );

  function automatic logic [AW-1:0] adr(input op_e k, input int i);
    if (k == STAT || k == WSTAT) return '0;
    return AW'(128 + 4 * i);
  endfunction

  task automatic drive_port(input int p, input op_e k, input int i);
    logic s, r, w;
    s = (k != IDLE);
    r = (k == CLAIM || k == STAT || k == NOSEL || k == RDWR);
    w = (k == REL || k == WSTAT || k == RDWR);
    if (k == NOSEL) s = 0;
    if (p == 0) begin
      c0_sel = s; c0_rd = r; c0_wr = w; c0_addr = adr(k, i);
    end else begin
      c1_sel = s; c1_rd = r; c1_wr = w; c1_addr = adr(k, i);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected result.
  task automatic step(input op_e k0, input int i0, input op_e k1, input int i1, input string tag);
    exp_t ex;
    logic [31:0] nxt;
    @(negedge clk);
    drive_port(0, k0, i0);
    drive_port(1, k1, i1);
    ex.e0 = '0; ex.e1 = '0; ex.tag = tag;
    nxt = model;
    if (k0 == STAT) ex.e0 = model;
    if (k1 == STAT) ex.e1 = model;
    if ((k0 == CLAIM || k0 == RDWR) && !model[i0]) begin
      ex.e0 = 32'h1 << i0;
    end
    if ((k1 == CLAIM || k1 == RDWR) && !model[i1] &&
        !((k0 == CLAIM || k0 == RDWR) && i0 == i1)) begin
      ex.e1 = 32'h1 << i1;
    end
    if (k0 == REL) nxt[i0] = 1'b0;
    if (k1 == REL) nxt[i1] = 1'b0;
    nxt = nxt | ex.e0 | ((k1 == STAT) ? 32'h0 : ex.e1) & ~((k0 == STAT) ? 32'h0 : 32'h0);
    if (k0 == STAT) nxt = (nxt & ~ex.e0) | (model & ex.e0) | (nxt & model);
    q.push_back(ex);
    model = nxt;
  endtask

  // Monitor: compares registered read data after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t ex;
        ex = q.pop_front();
        total += 2;
        if (c0_rdata !== ex.e0) begin
          bad++;
          $display("FAIL %s core0: actual=%h expected=%h", ex.tag, c0_rdata, ex.e0);
        end
        if (c1_rdata !== ex.e1) begin
          bad++;
          $display("FAIL %s core1: actual=%h expected=%h", ex.tag, c1_rdata, ex.e1);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (c0_rdata !== '0 || c1_rdata !== '0) begin
      bad++;
      $display("FAIL R1 rdata in reset: actual=%h/%h expected=0", c0_rdata, c1_rdata);
    end
    @(negedge clk);
    rst = 0;
    step(STAT, 0, STAT, 0, "R1 status after reset");
    step(IDLE, 0, IDLE, 0, "R10 idle");
    step(CLAIM, 5, IDLE, 0, "R3 R2 claim flag 5");
    step(IDLE, 0, CLAIM, 5, "R4 R9 held flag reads 0");
    step(IDLE, 0, STAT, 0, "R8 status shows flag 5");
    step(IDLE, 0, CLAIM, 31, "R3 top flag");
    step(CLAIM, 0, IDLE, 0, "R3 bottom flag");
    step(STAT, 0, IDLE, 0, "R8 status three flags");
    step(REL, 5, IDLE, 0, "R5 release flag 5");
    step(IDLE, 0, CLAIM, 5, "R5 released flag claimable");
    step(CLAIM, 7, CLAIM, 7, "R6 core0 wins contention");
    step(REL, 7, CLAIM, 7, "R7 release vs claim returns 0");
    step(IDLE, 0, CLAIM, 7, "R7 flag free after race");
    step(WSTAT, 0, IDLE, 0, "R5 write to status ignored");
    step(STAT, 0, IDLE, 0, "R5 status unchanged");
    step(NOSEL, 9, IDLE, 0, "R10 read without select");
    step(IDLE, 0, CLAIM, 9, "R10 no claim without select");
    step(RDWR, 12, IDLE, 0, "R10 read wins over write");
    step(STAT, 0, STAT, 0, "R10 flag 12 held after rd+wr");
    for (int i = 0; i < N; i++) begin
      step(REL, i, IDLE, 0, "R5 clear all");
    end
    step(STAT, 0, IDLE, 0, "R5 all free");
    for (int i = 0; i < N; i++) begin
      if (i % 2 == 0) step(CLAIM, i, CLAIM, (i + 1) % N, "R3 sweep");
      else            step(CLAIM, i, IDLE, 0, "R4 sweep");
    end
    step(STAT, 0, STAT, 0, "R8 all held");
    step(IDLE, 0, IDLE, 0, "R10 drain");
    @(posedge clk);
    #2;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule